// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register

This block is a W-bit storage register placed between two parallel buses, called A and B, with an extra one-bit serial data input. Four control inputs select its mode. The first chooses serial shifting or parallel transfer. The second sets the direction, A side or B side. The third gates the A side. The fourth makes a parallel transfer either clocked or flow-through. In every mode the register drives at most one bus, and it may load from the other bus or from the serial input.

Each bus is split into an input port, an output port and an output-enable, so that the pad tristate logic can sit outside the block. When the A-side gate is low in the A-to-B direction, the register keeps its own contents and still drives B. In flow-through parallel mode the driven bus follows the source bus without waiting for a clock edge. The register also samples the source bus on every rising edge, so the value stays in place after flow-through mode is left.

Top module: `bidir_bus_reg`

## Requirements
- R1: While reset is asserted and on the first edge after its synchronised release, the register holds all zeros. This is visible on b_out with par_sel=1, dir_b=1, a_en=0.
- R2: When par_sel=0, every rising edge shifts the register one place toward bit W-1, and ser_in enters bit 0.
- R3: When par_sel=0 and dir_b=0, a_oe equals a_en and b_oe is 0. When par_sel=0 and dir_b=1, b_oe is 1 and a_oe is 0.
- R4: When par_sel=1 and dir_b=0, the register loads b_in on each rising edge, a_oe equals a_en and b_oe is 0.
- R5: When par_sel=1, dir_b=1 and a_en=1, the register loads a_in on each rising edge, b_oe is 1 and a_oe is 0.
- R6: When par_sel=1, dir_b=1 and a_en=0, a_in is ignored: the register keeps its value across edges, b_oe is 1 and a_oe is 0.
- R7: When par_sel=1 and async_sel=1, a_out and b_out follow the source bus in the same cycle, with no clock edge. The source is b_in when dir_b=0 and a_in when dir_b=1 with a_en=1.
- R8: a_out and b_out always carry the same value, and a_oe and b_oe are never both 1.
- R9: Outside flow-through mode, the outputs show the stored value and do not change between clock edges when the bus inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial data shifted into bit 0 |
| par_sel | input | 1 | 1 selects parallel transfer, 0 selects serial shifting |
| dir_b | input | 1 | 0 selects the A side as output, 1 selects the B side as output |
| a_en | input | 1 | A-side gate: enables the A outputs or the A inputs, depending on direction |
| async_sel | input | 1 | 1 makes a parallel transfer flow-through, 0 makes it clocked |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The output-enables and the flow-through values are combinational, so they are due in the same cycle in which the controls or buses change. Register contents appear only after the next rising edge. The bench therefore drives the inputs 2 ns after a rising edge and samples all outputs at the falling edge, 4 ns after that edge. Its reference model advances at each rising edge using the inputs held across that edge. Two directed cases change a bus in the middle of a cycle, with no edge in between. They confirm that flow-through mode tracks the bus and that clocked mode keeps the stored value.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [2:0] {
    MD_SHIFT_A = 3'd0,
    MD_SHIFT_B = 3'd1,
    MD_PAR_B2A = 3'd2,
    MD_PAR_A2B = 3'd3,
    MD_RECIRC  = 3'd4
  } bbr_mode_e;
endpackage

// File: rtl/bbr_rst_sync.sv
module bbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bbr_mode_dec.sv
module bbr_mode_dec
  import bbr_pkg::*;
(
  input  logic      par_sel,
  input  logic      dir_b,
  input  logic      a_en,
  input  logic      async_sel,
  output bbr_mode_e mode,
  output logic      a_oe,
  output logic      b_oe,
  output logic      flow
);
  always_comb begin
    if (!par_sel)   mode = dir_b ? MD_SHIFT_B : MD_SHIFT_A;
    else if (!dir_b) mode = MD_PAR_B2A;
    else if (a_en)   mode = MD_PAR_A2B;
    else             mode = MD_RECIRC;

    a_oe = a_en && (mode == MD_SHIFT_A || mode == MD_PAR_B2A);
    b_oe = (mode == MD_SHIFT_B) || (mode == MD_PAR_A2B) || (mode == MD_RECIRC);
    flow = async_sel && (mode == MD_PAR_B2A || mode == MD_PAR_A2B);
  end
endmodule

// File: rtl/bbr_datapath.sv
module bbr_datapath
  import bbr_pkg::*;
#(
  parameter int W = 8
) (
  input  bbr_mode_e      mode,
  input  logic           flow,
  input  logic           ser_in,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [W-1:0]   q,
  output logic [W-1:0]   d,
  output logic           ld_en,
  output logic [W-1:0]   view
);
  localparam int MSB = W - 1;

  logic [W-1:0] shifted;
  logic [W-1:0] par_src;

  assign shifted[0] = ser_in;
  for (genvar i = 1; i <= MSB; i++) begin : g_shift
    assign shifted[i] = q[i-1];
  end

  assign par_src = (mode == MD_PAR_B2A) ? b_in : a_in;

  always_comb begin
    d     = q;
    ld_en = 1'b1;
    unique case (mode)
      MD_SHIFT_A, MD_SHIFT_B: d = shifted;
      MD_PAR_B2A, MD_PAR_A2B: d = par_src;
      default: begin
        d     = q;
        ld_en = 1'b0;
      end
    endcase
  end

  assign view = flow ? par_src : q;
endmodule

// File: rtl/bbr_store.sv
module bbr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_en) q <= d;
  end

  assert_clear_R1: assert property (@(posedge clk) $rose(rst_n) |-> (q == '0))
    else $error("register not clear after reset release");
endmodule

// File: rtl/bidir_bus_reg.sv
module bidir_bus_reg
  import bbr_pkg::*;
#(
  parameter int W         = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         par_sel,
  input  logic         dir_b,
  input  logic         a_en,
  input  logic         async_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic         rst_q_n;
  bbr_mode_e    mode;
  logic         flow;
  logic [W-1:0] q_r;
  logic [W-1:0] d_n;
  logic         ld_en;
  logic [W-1:0] view;

  bbr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  bbr_mode_dec u_dec (
    .par_sel(par_sel), .dir_b(dir_b), .a_en(a_en), .async_sel(async_sel),
    .mode(mode), .a_oe(a_oe), .b_oe(b_oe), .flow(flow)
  );

  bbr_datapath #(.W(W)) u_dp (
    .mode(mode), .flow(flow), .ser_in(ser_in), .a_in(a_in), .b_in(b_in),
    .q(q_r), .d(d_n), .ld_en(ld_en), .view(view)
  );

  bbr_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_q_n), .ld_en(ld_en), .d(d_n), .q(q_r)
  );

  assign a_out = view;
  assign b_out = view;

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !par_sel |=> (q_r == {$past(q_r[W-2:0]), $past(ser_in)}))
    else $error("serial shift wrong");

  assert_serial_oe_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !par_sel |-> ((a_oe == (a_en && !dir_b)) && (b_oe == dir_b)))
    else $error("serial enables wrong");

  assert_load_b_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (par_sel && !dir_b) |=> (q_r == $past(b_in)))
    else $error("B load wrong");

  assert_load_a_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (par_sel && dir_b && a_en) |=> (q_r == $past(a_in)))
    else $error("A load wrong");

  assert_recirc_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (par_sel && dir_b && !a_en) |=> $stable(q_r))
    else $error("recirculation changed register");

  assert_flow_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (par_sel && async_sel && !dir_b) |-> (a_out == b_in))
    else $error("flow-through does not track B");

  assert_oe_excl_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(a_oe && b_oe))
    else $error("both buses driven");

  assert_sync_view_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(par_sel && async_sel) |-> (b_out == q_r))
    else $error("clocked mode output not the stored value");
endmodule

// File: tb/bidir_bus_reg_test.sv
`timescale 1ns/1ps
module bidir_bus_reg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_in = 1'b0, par_sel = 1'b1, dir_b = 1'b1, a_en = 1'b0, async_sel = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  logic [W-1:0] mq;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bidir_bus_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .par_sel(par_sel), .dir_b(dir_b),
    .a_en(a_en), .async_sel(async_sel), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_view();
    if (par_sel && async_sel && !dir_b) return b_in;
    if (par_sel && async_sel && dir_b && a_en) return a_in;
    return mq;
  endfunction

  function automatic string mode_tag();
    if (par_sel && async_sel && (!dir_b || a_en)) return "R7";
    if (!par_sel) return "R2";
    if (!dir_b) return "R4";
    if (a_en) return "R5";
    return "R6";
  endfunction

  function automatic string oe_tag();
    if (!par_sel) return "R3";
    if (!dir_b) return "R4";
    if (a_en) return "R5";
    return "R6";
  endfunction

  task automatic model_edge();
    if (!par_sel)     mq = {mq[W-2:0], ser_in};
    else if (!dir_b)  mq = b_in;
    else if (a_en)    mq = a_in;
  endtask

  task automatic compare_all();
    chk(mode_tag(), "a_out", a_out, exp_view());
    chk("R8", "b_out", b_out, exp_view());
    chk(oe_tag(), "a_oe", {7'b0, a_oe}, {7'b0, (!dir_b && a_en)});
    chk(oe_tag(), "b_oe", {7'b0, b_oe}, {7'b0, dir_b});
  endtask

  task automatic step(logic p, logic d, logic e, logic s, logic si,
                      logic [W-1:0] a, logic [W-1:0] b);
    @(posedge clk);
    model_edge();
    #2;
    par_sel = p; dir_b = d; a_en = e; async_sel = s; ser_in = si; a_in = a; b_in = b;
    #2;
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    mq = '0;
    // R1: reset state, recirculate mode drives B
    repeat (4) @(posedge clk);
    #4;
    chk("R1", "b_out in reset", b_out, '0);
    chk("R1", "b_oe in reset", {7'b0, b_oe}, 8'h01);
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) begin
      @(posedge clk);
      #4 chk("R1", "b_out after release", b_out, '0);
    end

    // every control combination, random data
    for (int rep = 0; rep < 40; rep++) begin
      for (int c = 0; c < 16; c++) begin
        step(c[3], c[2], c[1], c[0], 1'($urandom), W'($urandom), W'($urandom));
      end
    end

    // serial ones walk toward MSB (R2)
    for (int k = 0; k < W + 2; k++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0);
    @(posedge clk); model_edge(); #4;
    chk("R2", "serial fill", b_out, mq);

    // R6: recirculation ignores A while driving B
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h69, 8'h00);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, W'($urandom), 8'h00);
    @(posedge clk); model_edge(); #4;
    chk("R6", "recirc holds", b_out, 8'h69);

    // R9: clocked B-to-A, bus changes mid-cycle do not reach the output
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA5);
    @(posedge clk); model_edge();
    #1 b_in = 8'h0F;
    #2 chk("R9", "clocked hold after change", a_out, 8'hA5);
    #2 b_in = 8'h33;
    #1 chk("R9", "clocked hold second change", a_out, 8'hA5);

    // R7: flow-through follows the bus with no edge
    @(posedge clk); model_edge();
    #1 async_sel = 1'b1; b_in = 8'h5A;
    #1 chk("R7", "flow B to A", a_out, 8'h5A);
    #1 b_in = 8'hC3;
    #1 chk("R7", "flow B to A retrack", a_out, 8'hC3);
    @(posedge clk); model_edge();
    #1 dir_b = 1'b1; a_en = 1'b1; a_in = 8'h96;
    #1 chk("R7", "flow A to B", b_out, 8'h96);
    chk("R5", "b_oe in A to B", {7'b0, b_oe}, 8'h01);
    // leaving flow-through keeps the value captured at the edge
    @(posedge clk); model_edge();
    #1 async_sel = 1'b0; dir_b = 1'b1; a_en = 1'b0;
    #2 chk("R7", "value kept after flow", b_out, 8'h96);

    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule